// File: doc/BRIEF.md
# IO bank freeze/thaw sequencer

This block moves the pad controls of four IO channels between a frozen pattern and an operating pattern. Three of the channels are plain. They carry slew-enable, weak-pullup, tristate and bus-hold controls, all active low, and an active-high configuration-done flag. The fourth channel, the hot channel, adds four controls: a register reset, a termination reset, a termination calibration enable and a DLL reset. Each channel reports whether it is currently frozen.

A host asks for a freeze or a thaw with a one-cycle request pulse and gets a one-cycle acknowledge back. Before it changes any pad control, the block switches the freeze source over to itself. It then applies the steps one at a time: the plain channels first in ascending order, then the hot channel. A single shared down-counter enforces the minimum spacing between steps. Every spacing is given in nanoseconds or in internal-oscillator periods, converted to clock cycles by rounding up, and is never less than one cycle. A one-cycle done pulse closes each sequence.

Top module: `iofrz_seq`

## Requirements
- R1: After reset every channel reports frozen (`frozen` all ones) and `src_sw` is 0. The plain channels drive all five controls at 0. The hot channel drives slew, pullup, tristate, bus-hold, config-done and calibration enable at 0, and register reset, termination reset and DLL reset at 1.
- R2: An idle block accepts `req_valid` (`req_thaw`=1 means thaw, 0 means freeze) and pulses `req_ack` for exactly one cycle on the next edge. If a sequence starts, `src_sw` is set on that same edge and the first control change follows one cycle later.
- R3: Freezing a plain channel first drops slew, pullup and tristate together. After at least 20 ns it drops bus-hold and config-done together, and that channel's status bit goes to 1.
- R4: Thawing a plain channel first raises bus-hold and config-done. After at least 20 ns it raises pullup and tristate, and after at least another 20 ns it raises slew, at which point the status bit goes to 0.
- R5: Channels are handled in the order 0, 1, 2, hot, with one cycle between the last step of one channel and the first step of the next, for both directions.
- R6: Freezing the hot channel takes three steps, one cycle apart: slew, pullup and tristate go low; then bus-hold and config-done go low while register reset and termination reset go high; then calibration enable goes low and DLL reset goes high, and status bit 3 goes to 1.
- R7: Thawing the hot channel first releases DLL reset. After at least 40 ns it raises calibration enable, then waits 1000 oscillator periods.
- R8: The hot thaw then raises bus-hold and config-done and drops termination reset, and waits 33 oscillator periods. It raises pullup and tristate, drops register reset at least 40 ns later, and raises slew at least 40 ns after that, clearing status bit 3.
- R9: A request that arrives while `busy` is high gets no acknowledge and does not change the sequence that is running.
- R10: A request for the state the block is already in gives `req_ack` and `seq_done` on the same edge and changes no output.
- R11: `seq_done` is a one-cycle pulse on the edge of the last control change, and `busy` is low from that edge on.
- R12: Each spacing is the duration divided by the clock period, rounded up, with a minimum of 1. With a 5 ns clock and a 50 MHz oscillator the spacings are 4, 8, 4000 and 132 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse |
| req_thaw | input | 1 | Requested direction: 1 thaw, 0 freeze |
| req_ack | output | 1 | One-cycle acknowledge of an accepted request |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| busy | output | 1 | Sequence in progress |
| src_sw | output | 1 | Freeze source set to this sequencer |
| s_slew_n | output | NS | Plain-channel slew enable, active low |
| s_pull_n | output | NS | Plain-channel weak pullup, active low |
| s_tri_n | output | NS | Plain-channel tristate, active low |
| s_hold_n | output | NS | Plain-channel bus-hold, active low |
| s_cfg_done | output | NS | Plain-channel configuration done |
| h_slew_n | output | 1 | Hot-channel slew enable, active low |
| h_pull_n | output | 1 | Hot-channel weak pullup, active low |
| h_tri_n | output | 1 | Hot-channel tristate, active low |
| h_hold_n | output | 1 | Hot-channel bus-hold, active low |
| h_cfg_done | output | 1 | Hot-channel configuration done |
| h_reg_rst | output | 1 | Hot-channel register reset |
| h_oct_rst | output | 1 | Hot-channel termination reset |
| h_cal_en | output | 1 | Hot-channel termination calibration enable |
| h_dll_rst | output | 1 | Hot-channel DLL reset |
| frozen | output | NS+1 | Per-channel frozen status, bit NS is the hot channel |

## Verification
The bench compares every change of the full control bus with a queue of expected snapshots, each carrying the exact number of cycles since the previous change. A thaw from the reset state tests the first-use path, where the source switch comes one cycle before the first step. A later thaw, started with the source already switched, tests the path that skips that switch. A freeze between them exercises the reverse order and the unspaced hot-channel steps. Requests for the state already held, and a request injected partway through a running thaw, separate the immediate-completion path from the ignore path: the first must acknowledge with no bus change, and the second must leave the queued sequence undisturbed.

// File: rtl/iofrz_pkg.sv
package iofrz_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STEP = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    // controls of a plain channel; all zero is the frozen pattern
    typedef struct packed {
        logic slew_n;
        logic pull_n;
        logic tri_n;
        logic hold_n;
        logic cfg_done;
    } simple_ctl_t;

    // controls of the hot channel
    typedef struct packed {
        logic slew_n;
        logic pull_n;
        logic tri_n;
        logic hold_n;
        logic cfg_done;
        logic reg_rst;
        logic oct_rst;
        logic cal_en;
        logic dll_rst;
    } hot_ctl_t;

    localparam hot_ctl_t HOT_FROZEN = 9'b00000_1101;

    // duration in ps -> clock cycles, rounded up, minimum one
    function automatic int unsigned ps_to_cyc(longint unsigned dur_ps,
                                              longint unsigned clk_ps);
        longint unsigned n;
        n = (dur_ps + clk_ps - 1) / clk_ps;
        if (n == 0) n = 1;
        return int'(n);
    endfunction

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/iofrz_timer.sv
module iofrz_timer #(
    parameter int unsigned TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == TW'(1));

    // the shared counter is only reloaded once the previous wait has run out
    assert_load_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt_q == '0));

endmodule

// File: rtl/iofrz_ctrl.sv
module iofrz_ctrl
    import iofrz_pkg::*;
#(
    parameter int unsigned NS      = 3,
    parameter int unsigned G_SHORT = 4,
    parameter int unsigned G_LONG  = 8,
    parameter int unsigned W_CAL   = 4000,
    parameter int unsigned W_OCT   = 132,
    parameter int unsigned TW      = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_thaw,
    input  logic                 tmr_expire,
    output logic                 tmr_load,
    output logic [TW-1:0]        tmr_val,
    output logic                 ack,
    output logic                 done,
    output logic                 busy,
    output logic                 src_sw,
    output simple_ctl_t [NS-1:0] sc,
    output hot_ctl_t             hc,
    output logic [NS:0]          frozen
);
    localparam int unsigned CH_W = $clog2(NS + 1);
    localparam int unsigned SI_W = (NS > 1) ? $clog2(NS) : 1;

    typedef struct packed {
        phase_e                phase;
        logic                  thaw;
        logic [CH_W-1:0]       ch;
        logic [2:0]            step;
        simple_ctl_t [NS-1:0]  sc;
        hot_ctl_t              hc;
        logic [NS:0]           frozen;
        logic                  src;
        logic                  ack;
        logic                  done;
    } st_t;

    st_t d, q;
    logic [TW-1:0] gap;
    logic          last;
    logic          end_ch;
    logic [SI_W-1:0] sidx;

    assign sidx = q.ch[SI_W-1:0];

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        gap      = TW'(1);
        last     = 1'b0;
        end_ch   = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    d.ack = 1'b1;
                    if (req_thaw ? (q.frozen == '0) : (&q.frozen)) begin
                        d.done = 1'b1;
                    end else begin
                        d.src   = 1'b1;
                        d.phase = PH_STEP;
                        d.thaw  = req_thaw;
                        d.ch    = '0;
                        d.step  = '0;
                    end
                end
            end
            PH_WAIT: begin
                if (tmr_expire) d.phase = PH_STEP;
            end
            PH_STEP: begin
                if (q.ch == CH_W'(NS)) begin
                    // hot channel
                    if (!q.thaw) begin
                        unique case (q.step)
                            3'd0: begin
                                d.hc.slew_n = 1'b0;
                                d.hc.pull_n = 1'b0;
                                d.hc.tri_n  = 1'b0;
                            end
                            3'd1: begin
                                d.hc.hold_n   = 1'b0;
                                d.hc.cfg_done = 1'b0;
                                d.hc.reg_rst  = 1'b1;
                                d.hc.oct_rst  = 1'b1;
                            end
                            default: begin
                                d.hc.cal_en    = 1'b0;
                                d.hc.dll_rst   = 1'b1;
                                d.frozen[NS]   = 1'b1;
                                last           = 1'b1;
                            end
                        endcase
                    end else begin
                        unique case (q.step)
                            3'd0: begin
                                d.hc.dll_rst = 1'b0;
                                gap = TW'(G_LONG);
                            end
                            3'd1: begin
                                d.hc.cal_en = 1'b1;
                                gap = TW'(W_CAL);
                            end
                            3'd2: begin
                                d.hc.hold_n   = 1'b1;
                                d.hc.cfg_done = 1'b1;
                                d.hc.oct_rst  = 1'b0;
                                gap = TW'(W_OCT);
                            end
                            3'd3: begin
                                d.hc.pull_n = 1'b1;
                                d.hc.tri_n  = 1'b1;
                                gap = TW'(G_LONG);
                            end
                            3'd4: begin
                                d.hc.reg_rst = 1'b0;
                                gap = TW'(G_LONG);
                            end
                            default: begin
                                d.hc.slew_n  = 1'b1;
                                d.frozen[NS] = 1'b0;
                                last         = 1'b1;
                            end
                        endcase
                    end
                end else begin
                    // plain channel
                    if (!q.thaw) begin
                        if (q.step == 3'd0) begin
                            d.sc[sidx].slew_n = 1'b0;
                            d.sc[sidx].pull_n = 1'b0;
                            d.sc[sidx].tri_n  = 1'b0;
                            gap = TW'(G_SHORT);
                        end else begin
                            d.sc[sidx].hold_n   = 1'b0;
                            d.sc[sidx].cfg_done = 1'b0;
                            d.frozen[q.ch]      = 1'b1;
                            end_ch              = 1'b1;
                        end
                    end else begin
                        unique case (q.step)
                            3'd0: begin
                                d.sc[sidx].hold_n   = 1'b1;
                                d.sc[sidx].cfg_done = 1'b1;
                                gap = TW'(G_SHORT);
                            end
                            3'd1: begin
                                d.sc[sidx].pull_n = 1'b1;
                                d.sc[sidx].tri_n  = 1'b1;
                                gap = TW'(G_SHORT);
                            end
                            default: begin
                                d.sc[sidx].slew_n = 1'b1;
                                d.frozen[q.ch]    = 1'b0;
                                end_ch            = 1'b1;
                            end
                        endcase
                    end
                end
                if (last) begin
                    d.done  = 1'b1;
                    d.phase = PH_IDLE;
                end else begin
                    if (end_ch) begin
                        d.ch   = CH_W'(q.ch + 1'b1);
                        d.step = '0;
                    end else begin
                        d.step = q.step + 3'd1;
                    end
                    if (gap > TW'(1)) begin
                        tmr_load = 1'b1;
                        tmr_val  = gap - TW'(1);
                        d.phase  = PH_WAIT;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.hc     <= HOT_FROZEN;
            q.frozen <= '1;
        end else begin
            q <= d;
        end
    end

    assign ack    = q.ack;
    assign done   = q.done;
    assign busy   = (q.phase != PH_IDLE);
    assign src_sw = q.src;
    assign sc     = q.sc;
    assign hc     = q.hc;
    assign frozen = q.frozen;

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.ack |=> !q.ack);

    assert_status_after_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.frozen) |-> $past(q.src));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_busy_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !q.ack);

    assert_cal_after_dll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.hc.cal_en) |-> !$past(q.hc.dll_rst));

    assert_hold_after_pads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.hc.hold_n) |-> (!$past(q.hc.tri_n) && !$past(q.hc.slew_n)));

    for (genvar i = 0; i < NS; i++) begin : g_chk
        assert_hold_after_pads_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(q.sc[i].hold_n) |-> (!$past(q.sc[i].pull_n) && !$past(q.sc[i].slew_n)));
        assert_pull_after_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.sc[i].pull_n) |-> $past(q.sc[i].hold_n));
        assert_slew_after_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.sc[i].slew_n) |-> $past(q.sc[i].pull_n));
    end

endmodule

// File: rtl/iofrz_seq.sv
module iofrz_seq
    import iofrz_pkg::*;
#(
    parameter int unsigned NS         = 3,
    parameter int unsigned CLK_PS     = 5000,
    parameter int unsigned GAP_S_NS   = 20,
    parameter int unsigned GAP_L_NS   = 40,
    parameter int unsigned OSC_PS     = 20000,
    parameter int unsigned CAL_OSC    = 1000,
    parameter int unsigned OCT_OSC    = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_thaw,
    output logic          req_ack,
    output logic          seq_done,
    output logic          busy,
    output logic          src_sw,
    output logic [NS-1:0] s_slew_n,
    output logic [NS-1:0] s_pull_n,
    output logic [NS-1:0] s_tri_n,
    output logic [NS-1:0] s_hold_n,
    output logic [NS-1:0] s_cfg_done,
    output logic          h_slew_n,
    output logic          h_pull_n,
    output logic          h_tri_n,
    output logic          h_hold_n,
    output logic          h_cfg_done,
    output logic          h_reg_rst,
    output logic          h_oct_rst,
    output logic          h_cal_en,
    output logic          h_dll_rst,
    output logic [NS:0]   frozen
);
    localparam int unsigned G_SHORT = ps_to_cyc(longint'(GAP_S_NS) * 1000, CLK_PS);
    localparam int unsigned G_LONG  = ps_to_cyc(longint'(GAP_L_NS) * 1000, CLK_PS);
    localparam int unsigned W_CAL   = ps_to_cyc(longint'(CAL_OSC) * OSC_PS, CLK_PS);
    localparam int unsigned W_OCT   = ps_to_cyc(longint'(OCT_OSC) * OSC_PS, CLK_PS);
    localparam int unsigned G_MAX   = max4(G_SHORT, G_LONG, W_CAL, W_OCT);
    localparam int unsigned TW      = $clog2(G_MAX + 1);

    logic                 tmr_load;
    logic [TW-1:0]        tmr_val;
    logic                 tmr_expire;
    simple_ctl_t [NS-1:0] sc;
    hot_ctl_t             hc;

    iofrz_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    iofrz_ctrl #(
        .NS      (NS),
        .G_SHORT (G_SHORT),
        .G_LONG  (G_LONG),
        .W_CAL   (W_CAL),
        .W_OCT   (W_OCT),
        .TW      (TW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_thaw   (req_thaw),
        .tmr_expire (tmr_expire),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .ack        (req_ack),
        .done       (seq_done),
        .busy       (busy),
        .src_sw     (src_sw),
        .sc         (sc),
        .hc         (hc),
        .frozen     (frozen)
    );

    for (genvar i = 0; i < NS; i++) begin : g_map
        assign s_slew_n[i]   = sc[i].slew_n;
        assign s_pull_n[i]   = sc[i].pull_n;
        assign s_tri_n[i]    = sc[i].tri_n;
        assign s_hold_n[i]   = sc[i].hold_n;
        assign s_cfg_done[i] = sc[i].cfg_done;
    end

    assign h_slew_n   = hc.slew_n;
    assign h_pull_n   = hc.pull_n;
    assign h_tri_n    = hc.tri_n;
    assign h_hold_n   = hc.hold_n;
    assign h_cfg_done = hc.cfg_done;
    assign h_reg_rst  = hc.reg_rst;
    assign h_oct_rst  = hc.oct_rst;
    assign h_cal_en   = hc.cal_en;
    assign h_dll_rst  = hc.dll_rst;

endmodule

// File: tb/test_iofrz_seq.sv
module test_iofrz_seq;
    localparam int NS = 3;
    localparam int VW = 1 + (NS + 1) + 9 + 5 * NS;
    // spacings derived by hand from R12: 5 ns clock, 50 MHz oscillator
    localparam int GS = 4;     // 20 ns
    localparam int GL = 8;     // 40 ns
    localparam int WC = 4000;  // 1000 oscillator periods
    localparam int WO = 132;   // 33 oscillator periods

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_thaw = 1'b0;
    logic req_ack, seq_done, busy, src_sw;
    logic [NS-1:0] s_slew_n, s_pull_n, s_tri_n, s_hold_n, s_cfg_done;
    logic h_slew_n, h_pull_n, h_tri_n, h_hold_n, h_cfg_done;
    logic h_reg_rst, h_oct_rst, h_cal_en, h_dll_rst;
    logic [NS:0] frozen;

    always #2.5 clk = ~clk;

    iofrz_seq i_iofrz_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thaw(req_thaw),
        .req_ack(req_ack), .seq_done(seq_done), .busy(busy), .src_sw(src_sw),
        .s_slew_n(s_slew_n), .s_pull_n(s_pull_n), .s_tri_n(s_tri_n),
        .s_hold_n(s_hold_n), .s_cfg_done(s_cfg_done),
        .h_slew_n(h_slew_n), .h_pull_n(h_pull_n), .h_tri_n(h_tri_n),
        .h_hold_n(h_hold_n), .h_cfg_done(h_cfg_done), .h_reg_rst(h_reg_rst),
        .h_oct_rst(h_oct_rst), .h_cal_en(h_cal_en), .h_dll_rst(h_dll_rst),
        .frozen(frozen)
    );

    typedef struct {
        logic [VW-1:0] vec;
        int            gap;   // -1: not checked
        string         tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_chg = 0;
    logic [VW-1:0] prev_vec;

    // reference model of the control bus
    logic [NS-1:0] m_slew, m_pull, m_tri, m_hold, m_cfg;
    logic mh_slew, mh_pull, mh_tri, mh_hold, mh_cfg, mh_reg, mh_oct, mh_cal, mh_dll;
    logic [NS:0] m_frz;
    logic m_src;

    function automatic logic [VW-1:0] model_vec();
        return {m_src, m_frz, mh_slew, mh_pull, mh_tri, mh_hold, mh_cfg, mh_reg,
                mh_oct, mh_cal, mh_dll, m_slew, m_pull, m_tri, m_hold, m_cfg};
    endfunction

    function automatic logic [VW-1:0] dut_vec();
        return {src_sw, frozen, h_slew_n, h_pull_n, h_tri_n, h_hold_n, h_cfg_done,
                h_reg_rst, h_oct_rst, h_cal_en, h_dll_rst,
                s_slew_n, s_pull_n, s_tri_n, s_hold_n, s_cfg_done};
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(int gap, string tag);
        exp_t e;
        e.vec = model_vec();
        e.gap = gap;
        e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: every bus change must match the next queued snapshot
    always @(negedge clk) begin
        if (rst_n) begin
            logic [VW-1:0] cur;
            cur = dut_vec();
            if (cur !== prev_vec) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9/R10", "unexpected bus change", longint'(cur), longint'(prev_vec));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cur === e.vec, e.tag, "bus value", longint'(cur), longint'(e.vec));
                    if (e.gap >= 0)
                        check((cyc - last_chg) == e.gap, e.tag, "spacing in cycles",
                              longint'(cyc - last_chg), longint'(e.gap));
                end
                last_chg = cyc;
            end
            prev_vec = cur;
        end
    end

    task automatic model_thaw();
        int g;
        g = -1;
        if (!m_src) begin
            m_src = 1'b1;
            push(-1, "R2");
            g = 1;
        end
        for (int i = 0; i < NS; i++) begin
            m_hold[i] = 1'b1; m_cfg[i] = 1'b1;
            push(g, "R4 R5");
            m_pull[i] = 1'b1; m_tri[i] = 1'b1;
            push(GS, "R4 R12");
            m_slew[i] = 1'b1; m_frz[i] = 1'b0;
            push(GS, "R4 R12");
            g = 1;
        end
        mh_dll = 1'b0;                                 push(1, "R5 R7");
        mh_cal = 1'b1;                                 push(GL, "R7 R12");
        mh_hold = 1'b1; mh_cfg = 1'b1; mh_oct = 1'b0;  push(WC, "R7 R12");
        mh_pull = 1'b1; mh_tri = 1'b1;                 push(WO, "R8 R12");
        mh_reg = 1'b0;                                 push(GL, "R8");
        mh_slew = 1'b1; m_frz[NS] = 1'b0;              push(GL, "R8");
    endtask

    task automatic model_freeze();
        int g;
        g = -1;
        if (!m_src) begin
            m_src = 1'b1;
            push(-1, "R2");
            g = 1;
        end
        for (int i = 0; i < NS; i++) begin
            m_slew[i] = 1'b0; m_pull[i] = 1'b0; m_tri[i] = 1'b0;
            push(g, "R3 R5");
            m_hold[i] = 1'b0; m_cfg[i] = 1'b0; m_frz[i] = 1'b1;
            push(GS, "R3 R12");
            g = 1;
        end
        mh_slew = 1'b0; mh_pull = 1'b0; mh_tri = 1'b0;  push(1, "R5 R6");
        mh_hold = 1'b0; mh_cfg = 1'b0; mh_reg = 1'b1; mh_oct = 1'b1;
        push(1, "R6");
        mh_cal = 1'b0; mh_dll = 1'b1; m_frz[NS] = 1'b1; push(1, "R6");
    endtask

    // pulse a request; returns after the edge that samples it
    task automatic pulse_req(bit thaw);
        @(negedge clk);
        req_valid = 1'b1;
        req_thaw  = thaw;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (seq_done !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(seq_done === 1'b1, "R11", "done pulse seen", longint'(seq_done), 1);
        check(busy === 1'b0, "R11", "busy low at done", longint'(busy), 0);
        @(negedge clk);
        check(seq_done === 1'b0, "R11", "done one cycle", longint'(seq_done), 0);
        check(sb.size() == 0, "R5", "all steps seen", longint'(sb.size()), 0);
    endtask

    initial begin
        m_slew = '0; m_pull = '0; m_tri = '0; m_hold = '0; m_cfg = '0;
        mh_slew = 0; mh_pull = 0; mh_tri = 0; mh_hold = 0; mh_cfg = 0;
        mh_reg = 1; mh_oct = 1; mh_cal = 0; mh_dll = 1;
        m_frz = '1; m_src = 1'b0;
        prev_vec = model_vec();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset pattern
        check(dut_vec() === model_vec(), "R1", "reset pattern",
              longint'(dut_vec()), longint'(model_vec()));
        check(busy === 1'b0 && req_ack === 1'b0, "R1", "idle after reset",
              longint'({busy, req_ack}), 0);

        // R10 freeze while already frozen
        pulse_req(1'b0);
        check(req_ack === 1'b1, "R10", "ack on same-state freeze", longint'(req_ack), 1);
        check(seq_done === 1'b1, "R10", "done with ack", longint'(seq_done), 1);
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R10", "stays idle", longint'(busy), 0);

        // first thaw, with a request injected while busy
        model_thaw();
        pulse_req(1'b1);
        check(req_ack === 1'b1, "R2", "ack on thaw", longint'(req_ack), 1);
        @(negedge clk);
        check(req_ack === 1'b0, "R2", "ack one cycle", longint'(req_ack), 0);
        repeat (10) @(negedge clk);
        check(busy === 1'b1, "R9", "busy during sequence", longint'(busy), 1);
        pulse_req(1'b0);
        check(req_ack === 1'b0, "R9", "no ack while busy", longint'(req_ack), 0);
        wait_done();
        check(frozen === '0, "R8", "all thawed", longint'(frozen), 0);

        // R10 thaw while already thawed
        pulse_req(1'b1);
        check(req_ack === 1'b1 && seq_done === 1'b1, "R10", "same-state thaw",
              longint'({req_ack, seq_done}), 3);
        repeat (3) @(negedge clk);

        // freeze
        model_freeze();
        pulse_req(1'b0);
        check(req_ack === 1'b1, "R2", "ack on freeze", longint'(req_ack), 1);
        wait_done();
        check(frozen === '1, "R6", "all frozen", longint'(frozen), 15);

        // thaw again with the source already selected
        model_thaw();
        pulse_req(1'b1);
        wait_done();
        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R9", "no stray changes", longint'(sb.size()), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule